// File: doc/BRIEF.md
# Dual-Bank 64-Source Interrupt Controller

This block collects 64 interrupt inputs into two 32-bit banks and drives a single interrupt request line to a processor. Each source is either edge-latched into an events register or level-followed, and a fixed per-bank configuration mask makes that choice bit by bit. Each bank keeps an events register, an enable mask and a copy of the live input levels. A bank requests service when an enabled bit is either latched or is a level-sensitive source that is currently high.

Software reaches the banks through a plain 32-bit register port with separate read and write strobes. It can read the events, mask and levels, write the mask, and clear latched events by writing ones. Data is byte-reversed in both directions at the port. Writes to the clear location cannot remove level-sensitive bits, so those sources stay pending until the input itself drops.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: Source n (bit n of `irq_in`) maps to bank 1 − (n >> 5) at bit n & 31: inputs 0..31 feed bank 1 and inputs 32..63 feed bank 0.
- R2: An edge-type source sets its events bit at the first clock edge where the input is high and was low at the previous edge. A level-sensitive source never sets its events bit.
- R3: At each clock edge the levels register of each bank takes the current value of its inputs.
- R4: `cpu_irq` is registered. After each edge it equals the OR over both banks of (events | (levels & level_cfg)) & mask, evaluated on the register values loaded at that same edge.
- R5: Address bits [11:4] select the bank: value 1 selects bank 0 (0x010..0x01F) and value 2 selects bank 1 (0x020..0x02F). Any other value returns zero on reads and changes nothing on writes.
- R6: Within a bank, address bits [3:0] select the register: 0x0 reads events, 0x4 reads and writes the mask, 0x8 is the clear location (it reads zero), and 0xC reads levels. Every other value reads zero and ignores writes.
- R7: A write to the clear location clears each events bit whose written bit is 1, except the bits marked level-sensitive in that bank, which are left unchanged.
- R8: Bus data is byte-reversed: bus byte i corresponds to register byte 3 − i, for both writes and reads (register value 0x00000001 appears on the bus as 0x01000000).
- R9: After reset, events, mask, levels, `rdata` and `cpu_irq` are zero. The level-sensitive mask is 0x00000000 in bank 0 and 0x1FF00000 in bank 1, so inputs 20..28 are level-sensitive.
- R10: If a rising input edge and a clear write hit the same events bit in the same cycle, the bit ends up set.
- R11: `rdata` is loaded at the edge that samples `rd_en` high, using the register state before that edge. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt sources, already synchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data (byte-reversed) |
| rdata | output | 32 | Read data (byte-reversed), registered |
| cpu_irq | output | 1 | Combined interrupt request, registered |

## Verification
Every result is due at the first edge after its stimulus. An input change, a mask write or a clear write shows on `cpu_irq` at that edge. The same edge loads `rdata` with the pre-edge register state, and a later read shows the new events and levels contents. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then samples on the next falling edge and compares against a bench model that it advances in step with that rising edge. It also checks that `rdata` holds across cycles without a read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned OFF_W    = 4;

  localparam logic [OFF_W-1:0] OFF_EVT = 4'h0;
  localparam logic [OFF_W-1:0] OFF_MSK = 4'h4;
  localparam logic [OFF_W-1:0] OFF_CLR = 4'h8;
  localparam logic [OFF_W-1:0] OFF_LVL = 4'hC;

  typedef struct packed {
    logic                mask_we;
    logic                clr_we;
    logic [WORD_W-1:0]   wval;
  } bank_wr_t;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_n;

  always_comb begin
    prev_n = sig_i;
    rise_o = sig_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_n;
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int unsigned      W       = WORD_W,
  parameter logic [W-1:0]     LVL_CFG = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  src_lvl,
  input  logic [W-1:0]  src_rise,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic [W-1:0]  wval,
  output logic [W-1:0]  events_q,
  output logic [W-1:0]  mask_q,
  output logic [W-1:0]  levels_q,
  output logic          req_next
);
  logic [W-1:0] events_n, mask_n, levels_n, clr_eff;

  always_comb begin
    // level-sensitive bits are protected from software clears
    clr_eff  = clr_we ? (wval & ~LVL_CFG) : '0;
    // a new edge wins over a simultaneous clear
    events_n = (events_q & ~clr_eff) | (src_rise & ~LVL_CFG);
    mask_n   = mask_we ? wval : mask_q;
    levels_n = src_lvl;
    req_next = |((events_n | (levels_n & LVL_CFG)) & mask_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      events_q <= '0;
      mask_q   <= '0;
      levels_q <= '0;
    end else begin
      events_q <= events_n;
      mask_q   <= mask_n;
      levels_q <= levels_n;
    end
  end
endmodule

// File: rtl/irqc_regport.sv
module irqc_regport
  import irqc_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned NBANK = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [AW-1:0]             addr,
  input  logic [W-1:0]              wdata,
  input  logic [NBANK-1:0][W-1:0]   events,
  input  logic [NBANK-1:0][W-1:0]   mask,
  input  logic [NBANK-1:0][W-1:0]   levels,
  output logic [NBANK-1:0]          mask_we,
  output logic [NBANK-1:0]          clr_we,
  output logic [W-1:0]              wval,
  output logic [W-1:0]              rdata
);
  localparam int unsigned NBYTE  = W / BYTE_W;
  localparam int unsigned PAGE_W = AW - OFF_W;

  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  off;
  logic [W-1:0]      rd_val, rd_swap;
  logic [W-1:0]      rdata_q, rdata_n;

  assign page = addr[AW-1:OFF_W];
  assign off  = addr[OFF_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < NBYTE; gi++) begin : g_swap
      assign wval[gi*BYTE_W +: BYTE_W]    = wdata[(NBYTE-1-gi)*BYTE_W +: BYTE_W];
      assign rd_swap[gi*BYTE_W +: BYTE_W] = rd_val[(NBYTE-1-gi)*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    mask_we = '0;
    clr_we  = '0;
    rd_val  = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (page == PAGE_W'(b + 1)) begin
        mask_we[b] = wr_en && (off == OFF_MSK);
        clr_we[b]  = wr_en && (off == OFF_CLR);
        case (off)
          OFF_EVT: rd_val = events[b];
          OFF_MSK: rd_val = mask[b];
          OFF_LVL: rd_val = levels[b];
          default: rd_val = '0;
        endcase
      end
    end
    rdata_n = rd_en ? rd_swap : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned                W       = WORD_W,
  parameter int unsigned                AW      = ADDR_W,
  parameter int unsigned                NBANK   = 2,
  parameter logic [NBANK-1:0][W-1:0]    LVL_CFG = {32'h1FF0_0000, 32'h0000_0000}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NBANK*W-1:0]   irq_in,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [W-1:0]         wdata,
  output logic [W-1:0]         rdata,
  output logic                 cpu_irq
);
  localparam int unsigned NSRC = NBANK * W;

  logic [NSRC-1:0]          rise;
  logic [NBANK-1:0][W-1:0]  events_all, mask_all, levels_all;
  logic [NBANK-1:0]         mask_we, clr_we, req_next;
  logic [W-1:0]             wval;
  logic                     irq_q, irq_n;

  irqc_edge #(.N(NSRC)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i (irq_in),
    .rise_o(rise)
  );

  irqc_regport #(.W(W), .AW(AW), .NBANK(NBANK)) u_port (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .events (events_all),
    .mask   (mask_all),
    .levels (levels_all),
    .mask_we(mask_we),
    .clr_we (clr_we),
    .wval   (wval),
    .rdata  (rdata)
  );

  // bank b serves sources with index (NBANK-1-b)*W .. +W-1
  genvar gb;
  generate
    for (gb = 0; gb < NBANK; gb++) begin : g_bank
      localparam int unsigned SRC_LO = (NBANK - 1 - gb) * W;
      irqc_bank #(.W(W), .LVL_CFG(LVL_CFG[gb])) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_lvl (irq_in[SRC_LO +: W]),
        .src_rise(rise[SRC_LO +: W]),
        .mask_we (mask_we[gb]),
        .clr_we  (clr_we[gb]),
        .wval    (wval),
        .events_q(events_all[gb]),
        .mask_q  (mask_all[gb]),
        .levels_q(levels_all[gb]),
        .req_next(req_next[gb])
      );
    end
  endgenerate

  always_comb irq_n = |req_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign cpu_irq = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned             W       = 32,
  parameter int unsigned             AW      = 12,
  parameter int unsigned             NBANK   = 2,
  parameter logic [NBANK-1:0][W-1:0] LVL_CFG = '0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [W-1:0]             irq_lo,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [AW-1:0]            addr,
  input logic [W-1:0]             rdata,
  input logic                     cpu_irq,
  input logic [NBANK-1:0][W-1:0]  ev,
  input logic [NBANK-1:0][W-1:0]  mk,
  input logic [NBANK-1:0][W-1:0]  lv
);
  logic seen_q;
  logic exp_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  always_comb begin
    exp_irq = 1'b0;
    for (int b = 0; b < NBANK; b++)
      exp_irq = exp_irq | (|((ev[b] | (lv[b] & LVL_CFG[b])) & mk[b]));
  end

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_lvl_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (lv[NBANK-1] == $past(irq_lo)));

  p_lvl_no_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[NBANK-1] & LVL_CFG[NBANK-1]) == '0);

  p_irq_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == exp_irq);

  p_bad_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr[AW-1:4] == '0 || addr[AW-1:4] > (AW-4)'(NBANK)))
    |=> ($stable(mk)));
endmodule

bind dual_bank_irq_ctrl irqc_checker #(
  .W(W), .AW(AW), .NBANK(NBANK), .LVL_CFG(LVL_CFG)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq_lo (irq_in[W-1:0]),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .rdata  (rdata),
  .cpu_irq(cpu_irq),
  .ev     (events_all),
  .mk     (mask_all),
  .lv     (levels_all)
);

// File: tb/dual_bank_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dual_bank_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_in;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        cpu_irq;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] m_ev [2];
  logic [31:0] m_mk [2];
  logic [31:0] m_lv [2];
  logic [31:0] m_cfg[2];
  logic [63:0] m_prev;
  logic [31:0] m_rdata;
  logic        m_irq;

  always #2 clk = ~clk;

  dual_bank_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_irq(cpu_irq)
  );

  function automatic logic [31:0] swap(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // bank index for a valid page, -1 otherwise (R5)
  function automatic int bank_of(logic [11:0] a);
    if (a[11:4] == 8'd1) return 0;
    if (a[11:4] == 8'd2) return 1;
    return -1;
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    int b = bank_of(a);
    if (b < 0) return 32'h0;
    case (a[3:0])
      4'h0: return swap(m_ev[b]);
      4'h4: return swap(m_mk[b]);
      4'hC: return swap(m_lv[b]);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, model at rising edge, check at next falling edge
  task automatic step(logic wr, logic rd, logic [11:0] a, logic [31:0] d, logic [63:0] irq);
    int b;
    logic [31:0] clr;
    wr_en = wr; rd_en = rd; addr = a; wdata = d; irq_in = irq;
    if (rd) m_rdata = model_read(a);
    @(posedge clk);
    b = bank_of(a);
    for (int k = 0; k < 2; k++) begin
      clr = (wr && b == k && a[3:0] == 4'h8) ? (swap(d) & ~m_cfg[k]) : 32'h0;
      m_ev[k] = m_ev[k] & ~clr;
      if (wr && b == k && a[3:0] == 4'h4) m_mk[k] = swap(d);
    end
    for (int n = 0; n < 64; n++) begin
      int bk = 1 - (n >> 5);
      int bt = n & 31;
      if (irq[n] && !m_prev[n] && !m_cfg[bk][bt]) m_ev[bk][bt] = 1'b1;
      m_lv[bk][bt] = irq[n];
    end
    m_prev = irq;
    m_irq = 1'b0;
    for (int k = 0; k < 2; k++)
      m_irq = m_irq | (|((m_ev[k] | (m_lv[k] & m_cfg[k])) & m_mk[k]));
    @(negedge clk);
    chk("R4 cpu_irq", {31'b0, cpu_irq}, {31'b0, m_irq});
    chk("R11 rdata", rdata, m_rdata);
  endtask

  task automatic rd(logic [11:0] a, logic [63:0] irq);
    step(1'b0, 1'b1, a, 32'h0, irq);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] irq;
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; irq_in = 0;
    for (int k = 0; k < 2; k++) begin m_ev[k] = 0; m_mk[k] = 0; m_lv[k] = 0; end
    m_cfg[0] = 32'h0; m_cfg[1] = 32'h1FF0_0000;
    m_prev = 0; m_rdata = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset cpu_irq", {31'b0, cpu_irq}, 32'h0);
    chk("R9 reset rdata", rdata, 32'h0);
    irq = 64'h0;
    rd(12'h014, irq); chk("R9 bank0 mask", rdata, 32'h0);
    rd(12'h020, irq); chk("R9 bank1 events", rdata, 32'h0);

    // R1/R2/R8: source 0 -> bank 1 bit 0, reads back byte-reversed
    irq[0] = 1'b1; step(0, 0, 12'h0, 0, irq);
    chk("R2 masked edge no irq", {31'b0, cpu_irq}, 32'h0);
    rd(12'h020, irq); chk("R1 R8 bank1 events bit0", rdata, 32'h0100_0000);
    rd(12'h010, irq); chk("R1 bank0 events empty", rdata, 32'h0);
    step(1, 0, 12'h024, 32'h0100_0000, irq);
    chk("R4 mask write raises irq", {31'b0, cpu_irq}, 32'h1);
    step(1, 0, 12'h028, 32'h0100_0000, irq);
    chk("R7 clear edge bit", {31'b0, cpu_irq}, 32'h0);

    // level source 20 in bank 1
    irq[20] = 1'b1; step(0, 0, 12'h0, 0, irq);
    rd(12'h020, irq); chk("R2 level no event", rdata, 32'h0);
    rd(12'h02C, irq); chk("R3 levels bits", rdata, swap(32'h0010_0001));
    step(1, 0, 12'h024, swap(32'h0010_0000), irq);
    chk("R4 level irq", {31'b0, cpu_irq}, 32'h1);
    step(1, 0, 12'h028, 32'hFFFF_FFFF, irq);
    chk("R7 level not clearable", {31'b0, cpu_irq}, 32'h1);
    irq[20] = 1'b0; step(0, 0, 12'h0, 0, irq);
    chk("R4 level drop", {31'b0, cpu_irq}, 32'h0);

    // source 32 -> bank 0 bit 0; R10 set wins over clear
    irq[32] = 1'b1; step(0, 0, 12'h0, 0, irq);
    rd(12'h010, irq); chk("R1 bank0 events bit0", rdata, 32'h0100_0000);
    irq[33] = 1'b1; step(1, 0, 12'h018, swap(32'h3), irq);
    rd(12'h010, irq); chk("R10 set beats clear", rdata, swap(32'h2));

    // R5/R6 decode
    step(1, 0, 12'h034, 32'hFFFF_FFFF, irq);
    step(1, 0, 12'h004, 32'hFFFF_FFFF, irq);
    rd(12'h034, irq); chk("R5 bad page read", rdata, 32'h0);
    rd(12'h014, irq); chk("R5 masks unchanged", rdata, 32'h0);
    rd(12'h018, irq); chk("R6 clear reads zero", rdata, 32'h0);
    step(1, 0, 12'h010, 32'h0, irq);
    step(1, 0, 12'h015, 32'hFFFF_FFFF, irq);
    rd(12'h010, irq); chk("R6 events not writable", rdata, swap(32'h2));
    rd(12'h014, irq); chk("R6 odd offset ignored", rdata, 32'h0);
    step(0, 0, 12'h0, 0, irq);
    chk("R11 rdata holds", rdata, 32'h0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic [3:0]  o;
      int sel = $urandom % 5;
      if ($urandom % 4 == 0) irq[$urandom % 64] ^= 1'b1;
      o = ($urandom % 6 == 0) ? 4'($urandom) : 4'(4 * ($urandom % 4));
      case (sel)
        0: a = {8'h00, o};
        1, 2: a = {8'h01, o};
        3: a = {8'h02, o};
        default: a = {8'($urandom), o};
      endcase
      case ($urandom % 3)
        0: step(1, 0, a, $urandom, irq);
        1: step(0, 1, a, 0, irq);
        default: step(0, 0, a, 0, irq);
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule